// File: doc/BRIEF.md
# GPIO Interrupt Detect and Routing Unit

This unit watches a set of already synchronised GPIO input levels and turns per-pin trigger conditions into interrupt events. Every pin carries its own trigger mode (edge or level, either polarity) and four routing enables. When a pin's condition is met, the pin's bit is raised in the interrupt-status word of its 32-pin bank. The same event is copied into up to four routed status words: a maskable and a non-maskable word for each of two CPUs (called here the application CPU and the protocol CPU).

Two combined outputs leave the block. The maskable line is high while any maskable copy holds a set bit in either bank. The non-maskable line follows the same rule for the non-maskable copies. Software reads the status and routed words through a small register port. It acknowledges events by writing ones to a per-bank clear alias, and a single such write clears the status bit and all four copies together.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every status word and routed copy reads zero, `irq_o` and `nmi_o` are low, and the latched previous level of every pin is 0.
- R2: Pin p is configured by bits [7p+6:7p] of `pin_cfg_i`. Bits [2:0] of that slice hold the trigger mode: 0 disabled, 1 rising edge, 2 falling edge, 3 any edge, 4 low level, 5 high level. Codes 0, 6 and 7 never set any bit.
- R3: The edge modes compare the present input level with the level latched at the previous clock edge. A qualifying change applied before a clock edge is visible in the status word right after that edge.
- R4: The level modes set the status bit at every clock edge while the condition holds. A clear written while the level condition is still active therefore leaves the bit set.
- R5: The routing enables are slice bits 3, 4, 5 and 6, for application maskable, application non-maskable, protocol maskable and protocol non-maskable. A trigger always sets the status bit, and sets a routed copy only when that copy's enable is 1.
- R6: `irq_o` is high exactly when any bit of either maskable copy is set in any bank. `nmi_o` is high exactly when any bit of either non-maskable copy is set in any bank.
- R7: A write to address 0x4C (pins 0..31) or 0x58 (pins 32..39) clears the bits given as ones in the data from that bank's status word and from all four of its copies. Bits written as zero and the other bank are unaffected.
- R8: After a clear, each output line drops only when all of its contributing copies in both banks are zero.
- R9: When a trigger and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: Read map: status at 0x44 (bank 0) and 0x50 (bank 1). Routed copies, in the order application maskable, application non-maskable, protocol maskable, protocol non-maskable, are at 0x60, 0x64, 0x68 and 0x6C for bank 0 and at 0x74, 0x78, 0x7C and 0x80 for bank 1. Every other address, the clear aliases included, reads 0. Writes to any address other than the two aliases have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl_i | input | 40 | Synchronised input level of each pin |
| pin_cfg_i | input | 280 | Per-pin 7-bit configuration: mode and four routing enables |
| bus_wr_i | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr_i | input | 8 | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Combined maskable interrupt line |
| nmi_o | output | 1 | Combined non-maskable interrupt line |

## Verification
The assertions assume that `pin_lvl_i` and `pin_cfg_i` are stable across each clock edge. They also assume that the configuration seen at one edge is the one that routed that edge's triggers. Their "falls only after a clear" properties further assume that nothing but a clear alias write can lower a routed copy.

The bench keeps within these assumptions. It changes pins, configuration and bus signals only on the falling clock edge, and it disables a pin's mode before returning the pin to idle. This means no unintended event is left pending when a check is made.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   typedef enum logic [2:0] {
      TM_OFF  = 3'd0,
      TM_RISE = 3'd1,
      TM_FALL = 3'd2,
      TM_ANY  = 3'd3,
      TM_LOW  = 3'd4,
      TM_HIGH = 3'd5,
      TM_RSV6 = 3'd6,
      TM_RSV7 = 3'd7
   } trig_mode_e;

   localparam int MODE_W     = 3;
   localparam int NUM_ROUTES = 4;
   localparam int CFG_W      = MODE_W + NUM_ROUTES;
   localparam int EN_LSB     = MODE_W;

   // route index inside a bank's copy array; order is the read order
   localparam int RT_APP_IRQ = 0;
   localparam int RT_APP_NMI = 1;
   localparam int RT_PRO_IRQ = 2;
   localparam int RT_PRO_NMI = 3;

   // register map, per-bank steps
   localparam int STAT_BASE = 'h44;
   localparam int CLR_BASE  = 'h4C;
   localparam int BANK_STEP = 'h0C;
   localparam int COPY_BASE = 'h60;
   localparam int COPY_STEP = 'h14;
   localparam int WORD_B    = 4;

endpackage

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS = 40
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_PINS-1:0]              lvl_i,
   input  logic [NUM_PINS-1:0][MODE_W-1:0]  mode_i,
   output logic [NUM_PINS-1:0]              fire_o
);

   logic [NUM_PINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      always_comb begin
         unique case (trig_mode_e'(mode_i[p]))
            TM_RISE: fire_o[p] =  lvl_i[p] & ~prev_q[p];
            TM_FALL: fire_o[p] = ~lvl_i[p] &  prev_q[p];
            TM_ANY:  fire_o[p] =  lvl_i[p] ^  prev_q[p];
            TM_LOW:  fire_o[p] = ~lvl_i[p];
            TM_HIGH: fire_o[p] =  lvl_i[p];
            default: fire_o[p] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_irq_pkg::*;
#(
   parameter int BANK_W = 32
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [BANK_W-1:0]                    trig_i,
   input  logic [NUM_ROUTES-1:0][BANK_W-1:0]    route_en_i,
   input  logic [BANK_W-1:0]                    clr_i,
   output logic [BANK_W-1:0]                    stat_o,
   output logic [NUM_ROUTES-1:0][BANK_W-1:0]    copy_o
);

   logic [BANK_W-1:0]                 stat_q;
   logic [NUM_ROUTES-1:0][BANK_W-1:0] copy_q;

   // a trigger in the same cycle as a clear wins: set is OR-ed after the mask
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_i) | trig_i;
   end

   for (genvar r = 0; r < NUM_ROUTES; r++) begin : g_route
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) copy_q[r] <= '0;
         else        copy_q[r] <= (copy_q[r] & ~clr_i) | (trig_i & route_en_i[r]);
      end
   end

   assign stat_o = stat_q;
   assign copy_o = copy_q;

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS = 40,
   parameter int BANK_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_PINS-1:0]          pin_lvl_i,
   input  logic [NUM_PINS*CFG_W-1:0]    pin_cfg_i,
   input  logic                         bus_wr_i,
   input  logic [ADDR_W-1:0]            bus_addr_i,
   input  logic [DATA_W-1:0]            bus_wdata_i,
   output logic [DATA_W-1:0]            bus_rdata_o,
   output logic                         irq_o,
   output logic                         nmi_o
);

   localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
   localparam int PAD_W     = NUM_BANKS * BANK_W;

   if (NUM_BANKS > 2) begin : g_chk_banks
      $error("gpio_irq_router: map holds at most two banks");
   end
   if (BANK_W > DATA_W) begin : g_chk_width
      $error("gpio_irq_router: bank wider than data bus");
   end
   if (ADDR_W < 8) begin : g_chk_addr
      $error("gpio_irq_router: address too narrow for the map");
   end

   // ---------------- configuration unpack ----------------
   logic [NUM_PINS-1:0][MODE_W-1:0] mode_w;
   logic [NUM_PINS-1:0]             fire_w;
   logic [PAD_W-1:0]                trig_pad;
   logic [NUM_ROUTES-1:0][PAD_W-1:0] en_pad;

   always_comb begin
      trig_pad = '0;
      en_pad   = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         mode_w[p]   = pin_cfg_i[p*CFG_W +: MODE_W];
         trig_pad[p] = fire_w[p];
         for (int r = 0; r < NUM_ROUTES; r++) begin
            en_pad[r][p] = pin_cfg_i[p*CFG_W + EN_LSB + r];
         end
      end
   end

   gpio_trig_detect #(.NUM_PINS(NUM_PINS)) u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (pin_lvl_i),
      .mode_i (mode_w),
      .fire_o (fire_w)
   );

   // ---------------- banks ----------------
   logic [BANK_W-1:0]                 stat_w [NUM_BANKS];
   logic [NUM_ROUTES-1:0][BANK_W-1:0] copy_w [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [NUM_ROUTES-1:0][BANK_W-1:0] en_b;
      logic [BANK_W-1:0]                 clr_b;
      logic                              hit_clr;

      assign hit_clr = bus_wr_i && (bus_addr_i == ADDR_W'(CLR_BASE + b*BANK_STEP));
      assign clr_b   = hit_clr ? bus_wdata_i[BANK_W-1:0] : '0;

      for (genvar r = 0; r < NUM_ROUTES; r++) begin : g_en
         assign en_b[r] = en_pad[r][b*BANK_W +: BANK_W];
      end

      gpio_irq_bank #(.BANK_W(BANK_W)) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .trig_i     (trig_pad[b*BANK_W +: BANK_W]),
         .route_en_i (en_b),
         .clr_i      (clr_b),
         .stat_o     (stat_w[b]),
         .copy_o     (copy_w[b])
      );
   end

   // ---------------- output lines ----------------
   always_comb begin
      irq_o = 1'b0;
      nmi_o = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         irq_o = irq_o | (|copy_w[b][RT_APP_IRQ]) | (|copy_w[b][RT_PRO_IRQ]);
         nmi_o = nmi_o | (|copy_w[b][RT_APP_NMI]) | (|copy_w[b][RT_PRO_NMI]);
      end
   end

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata_o = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bus_addr_i == ADDR_W'(STAT_BASE + b*BANK_STEP))
            bus_rdata_o = DATA_W'(stat_w[b]);
         for (int r = 0; r < NUM_ROUTES; r++) begin
            if (bus_addr_i == ADDR_W'(COPY_BASE + b*COPY_STEP + r*WORD_B))
               bus_rdata_o = DATA_W'(copy_w[b][r]);
         end
      end
   end

endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS = 40,
   parameter int BANK_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_PINS-1:0]       pin_lvl_i,
   input logic [NUM_PINS*CFG_W-1:0] pin_cfg_i,
   input logic                      bus_wr_i,
   input logic [ADDR_W-1:0]         bus_addr_i,
   input logic [DATA_W-1:0]         bus_rdata_o,
   input logic                      irq_o,
   input logic                      nmi_o
);

   localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;

   logic all_off, any_irq_en, any_nmi_en, hi_app_irq, clr_wr, mapped;

   always_comb begin
      all_off    = 1'b1;
      any_irq_en = 1'b0;
      any_nmi_en = 1'b0;
      hi_app_irq = 1'b0;
      for (int p = 0; p < NUM_PINS; p++) begin
         logic [MODE_W-1:0] m;
         m = pin_cfg_i[p*CFG_W +: MODE_W];
         if (m inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5}) all_off = 1'b0;
         if (pin_cfg_i[p*CFG_W + EN_LSB + RT_APP_IRQ] || pin_cfg_i[p*CFG_W + EN_LSB + RT_PRO_IRQ])
            any_irq_en = 1'b1;
         if (pin_cfg_i[p*CFG_W + EN_LSB + RT_APP_NMI] || pin_cfg_i[p*CFG_W + EN_LSB + RT_PRO_NMI])
            any_nmi_en = 1'b1;
         if (m == 3'd5 && pin_lvl_i[p] && pin_cfg_i[p*CFG_W + EN_LSB + RT_APP_IRQ])
            hi_app_irq = 1'b1;
      end
   end

   always_comb begin
      clr_wr = 1'b0;
      mapped = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bus_addr_i == ADDR_W'(CLR_BASE + b*BANK_STEP)) clr_wr = bus_wr_i;
         if (bus_addr_i == ADDR_W'(STAT_BASE + b*BANK_STEP)) mapped = 1'b1;
         for (int r = 0; r < NUM_ROUTES; r++)
            if (bus_addr_i == ADDR_W'(COPY_BASE + b*COPY_STEP + r*WORD_B)) mapped = 1'b1;
      end
   end

   // R4: an active high level routed to the application maskable copy raises irq
   a_r4_level_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      hi_app_irq |=> irq_o);

   // R2: with every mode disabled a quiet irq line stays quiet
   a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (all_off && !irq_o) |=> !irq_o);

   // R5: irq cannot rise without a maskable route enabled
   a_r5_irq_needs_route: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(any_irq_en));

   // R5: nmi cannot rise without a non-maskable route enabled
   a_r5_nmi_needs_route: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_o) |-> $past(any_nmi_en));

   // R8: irq drops only after a clear alias write
   a_r8_irq_fall_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(clr_wr));

   // R8: nmi drops only after a clear alias write
   a_r8_nmi_fall_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nmi_o) |-> $past(clr_wr));

   // R10: unmapped addresses read zero
   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (bus_rdata_o == '0));

endmodule

bind gpio_irq_router gpio_irq_router_chk #(
   .NUM_PINS (NUM_PINS),
   .BANK_W   (BANK_W),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pin_lvl_i   (pin_lvl_i),
   .pin_cfg_i   (pin_cfg_i),
   .bus_wr_i    (bus_wr_i),
   .bus_addr_i  (bus_addr_i),
   .bus_rdata_o (bus_rdata_o),
   .irq_o       (irq_o),
   .nmi_o       (nmi_o)
);

// File: tb/sim_gpio_irq_router.sv
`timescale 1ns/1ps
module sim_gpio_irq_router;

   localparam int NP = 40;
   localparam int CW = 7;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NP-1:0]  pin_lvl = '0;
   logic [NP*CW-1:0] pin_cfg = '0;
   logic           bus_wr = 1'b0;
   logic [7:0]     bus_addr = '0;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic           irq, nmi;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpio_irq_router u0 (
      .clk (clk), .rst_n (rst_n),
      .pin_lvl_i (pin_lvl), .pin_cfg_i (pin_cfg),
      .bus_wr_i (bus_wr), .bus_addr_i (bus_addr), .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata), .irq_o (irq), .nmi_o (nmi)
   );

   // vector: {pin[5:0], mode[2:0], en[3:0], lvl_before, lvl_after, fires}
   localparam int NV = 15;
   localparam bit [15:0] VEC [NV] = '{
      {6'd0,  3'd1, 4'b0001, 1'b0, 1'b1, 1'b1},
      {6'd0,  3'd1, 4'b0001, 1'b1, 1'b0, 1'b0},
      {6'd5,  3'd2, 4'b0010, 1'b1, 1'b0, 1'b1},
      {6'd5,  3'd2, 4'b0010, 1'b0, 1'b1, 1'b0},
      {6'd33, 3'd3, 4'b0100, 1'b0, 1'b1, 1'b1},
      {6'd33, 3'd3, 4'b1000, 1'b1, 1'b0, 1'b1},
      {6'd39, 3'd3, 4'b1111, 1'b1, 1'b1, 1'b0},
      {6'd7,  3'd4, 4'b1010, 1'b1, 1'b0, 1'b1},
      {6'd7,  3'd4, 4'b1010, 1'b0, 1'b1, 1'b0},
      {6'd34, 3'd5, 4'b0101, 1'b0, 1'b1, 1'b1},
      {6'd34, 3'd5, 4'b0101, 1'b1, 1'b0, 1'b0},
      {6'd2,  3'd6, 4'b1111, 1'b0, 1'b1, 1'b0},
      {6'd2,  3'd7, 4'b1111, 1'b1, 1'b0, 1'b0},
      {6'd31, 3'd0, 4'b1111, 1'b0, 1'b1, 1'b0},
      {6'd32, 3'd1, 4'b0000, 1'b0, 1'b1, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic setcfg(input int p, input logic [2:0] m, input logic [3:0] e);
      pin_cfg[p*CW +: CW] = {e, m};
   endtask

   task automatic clr_all();
      wr(8'h4C, 32'hFFFF_FFFF);
      wr(8'h58, 32'hFFFF_FFFF);
   endtask

   function automatic logic [7:0] stat_addr(input int bank);
      return (bank == 0) ? 8'h44 : 8'h50;
   endfunction

   function automatic logic [7:0] copy_addr(input int bank, input int r);
      return 8'((bank == 0 ? 'h60 : 'h74) + 4*r);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: got %h expected %h", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 nmi", {31'b0, nmi}, 32'h0);
      for (int b = 0; b < 2; b++) begin
         rd(stat_addr(b), d); check("R1 status", d, 0);
         for (int r = 0; r < 4; r++) begin
            rd(copy_addr(b, r), d); check("R1 copy", d, 0);
         end
      end

      // R2 R3 R4 R5 R6 R10: vector table
      for (int i = 0; i < NV; i++) begin
         int p, bank;
         logic [2:0] m;
         logic [3:0] e;
         logic bl, al, f;
         {p[5:0], m, e, bl, al, f} = VEC[i];
         p = int'(VEC[i][15:10]);
         bank = p / 32;
         setcfg(p, 3'd0, 4'd0);
         pin_lvl[p] = bl;
         tick();
         clr_all();
         setcfg(p, m, e);
         pin_lvl[p] = al;
         tick();
         w = f ? (32'h1 << (p % 32)) : 32'h0;
         rd(stat_addr(bank), d); check("R2/R3 status", d, w);
         for (int r = 0; r < 4; r++) begin
            rd(copy_addr(bank, r), d); check("R5 copy", d, e[r] ? w : 32'h0);
         end
         check("R6 irq", {31'b0, irq}, {31'b0, f & (e[0] | e[2])});
         check("R6 nmi", {31'b0, nmi}, {31'b0, f & (e[1] | e[3])});
         setcfg(p, 3'd0, 4'd0);
         pin_lvl[p] = 1'b0;
         tick();
         clr_all();
      end

      // R4: clear during an active low level is overridden
      setcfg(3, 3'd4, 4'b0001);
      pin_lvl[3] = 1'b0;
      tick();
      wr(8'h4C, 32'h8);
      rd(8'h44, d); check("R4 status kept", d, 32'h8);
      check("R4 irq kept", {31'b0, irq}, 32'h1);
      setcfg(3, 3'd0, 4'd0);
      tick();
      wr(8'h4C, 32'h8);
      rd(8'h44, d); check("R7 status cleared", d, 32'h0);
      rd(8'h60, d); check("R7 copy cleared", d, 32'h0);
      check("R7 irq low", {31'b0, irq}, 32'h0);

      // R9: trigger and clear on the same bit in the same cycle
      setcfg(8, 3'd1, 4'b0001);
      pin_lvl[8] = 1'b1;
      wr(8'h4C, 32'h100);
      rd(8'h44, d); check("R9 trigger wins", d, 32'h100);
      rd(8'h60, d); check("R9 copy set", d, 32'h100);
      setcfg(8, 3'd0, 4'd0);
      pin_lvl[8] = 1'b0;
      tick();
      clr_all();

      // R8 R7 R10: clears across banks
      setcfg(1, 3'd1, 4'b0001);
      setcfg(36, 3'd1, 4'b0100);
      setcfg(10, 3'd1, 4'b0010);
      pin_lvl[1] = 1'b1; pin_lvl[36] = 1'b1; pin_lvl[10] = 1'b1;
      tick();
      check("R6 irq both", {31'b0, irq}, 32'h1);
      check("R6 nmi both", {31'b0, nmi}, 32'h1);
      wr(8'h44, 32'hFFFF_FFFF);
      rd(8'h44, d); check("R10 status write ignored", d, 32'h402);
      rd(8'h48, d); check("R10 unmapped read", d, 32'h0);
      rd(8'h4C, d); check("R10 alias reads zero", d, 32'h0);
      wr(8'h4C, 32'h2);
      check("R8 irq held by bank1", {31'b0, irq}, 32'h1);
      check("R8 nmi held", {31'b0, nmi}, 32'h1);
      rd(8'h44, d); check("R7 other bits kept", d, 32'h400);
      rd(8'h50, d); check("R7 other bank kept", d, 32'h10);
      rd(8'h7C, d); check("R10 bank1 protocol irq copy", d, 32'h10);
      wr(8'h58, 32'h10);
      check("R8 irq drops", {31'b0, irq}, 32'h0);
      check("R8 nmi still held", {31'b0, nmi}, 32'h1);
      wr(8'h4C, 32'h400);
      check("R8 nmi drops", {31'b0, nmi}, 32'h0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule